// File: doc/BRIEF.md
# Paired Register Store Sequencer

This block carries out one paired-register store. A request presents a 32-bit instruction word together with a start strobe. From the word the block works out four things: the element width (32 or 64 bits), the scaled signed byte offset, the addressing form, and which registers take part. It reads the two data registers and the base through combinational register-file read ports. When the base index is 31 it uses a separate stack pointer input instead of the register file.

It then issues two memory writes, one per cycle, over a valid/ready port. The first register goes to the effective address. The second register goes to the slot directly above it. For the pre-index and post-index forms, the block then writes the updated address back to the base register or to the stack pointer. A one-cycle done pulse ends every request.

An encoding the block does not handle, or a misaligned stack pointer, ends the request at once. In that case a flag is raised together with the done pulse, and no memory or register write takes place.

Top module: `stp_seq`

## Requirements
- R1: Instruction fields are: Rt in [4:0], Rn in [9:5], Rt2 in [14:10], imm7 in [21:15], load bit in [22], index form in [24:23] (01 post, 11 pre, 10 signed offset), opc in [31:30]. Bits [29:25] are ignored. opc 00 gives 4-byte elements: the low 32 register bits are stored zero-extended, with `mem_size`=0. opc 10 gives 8-byte elements: all 64 bits are stored, with `mem_size`=1.
- R2: The request is illegal when any of these holds: opc is 11, the load bit is 0 with opc[0]=1, the load bit is 1, or the form is 00. An illegal request raises `illegal` with `done`, one cycle after start, and performs no memory or register write.
- R3: The byte offset is imm7 sign-extended and shifted left by 2 (4-byte elements) or by 3 (8-byte elements). This covers -256..252 and -512..504 respectively.
- R4: The pre-index and signed-offset forms write at base+offset. The post-index form writes at the unmodified base.
- R5: Each accepted legal request performs exactly two writes. The first stores Rt at the effective address. The second stores Rt2 at the effective address plus the element size in bytes.
- R6: The pre-index and post-index forms write base+offset back to the base register, or to the stack pointer when Rn is 31, after both memory writes. The signed-offset form performs no writeback.
- R7: Rn = 31 selects the stack pointer as base. If the stack pointer is not a multiple of 16, the block raises `align_fault` with `done`, one cycle after start, and performs no write of any kind.
- R8: When a data register is also the base register (Rn not 31), the value stored is the register's value before writeback.
- R9: `mem_valid` stays high with unchanged address and data until `mem_ready` is seen. While waiting, the block stalls by one cycle per cycle of `mem_ready` low.
- R10: `done` is a single-cycle pulse. With `mem_ready` held high, it arrives 4 cycles after start for pre/post forms and 3 cycles after start for the signed-offset form. After reset the block is idle with no outputs active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken while idle |
| instr | input | 32 | Instruction word, valid with start |
| busy | output | 1 | Request in progress |
| rf_raddr_a | output | 5 | Read index for first data register |
| rf_rdata_a | input | 64 | First data register value |
| rf_raddr_b | output | 5 | Read index for second data register |
| rf_rdata_b | input | 64 | Second data register value |
| rf_raddr_n | output | 5 | Read index for base register |
| rf_rdata_n | input | 64 | Base register value |
| sp_in | input | 64 | Current stack pointer |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 64 | Write byte address |
| mem_wdata | output | 64 | Write data |
| mem_size | output | 1 | 0 = 4 bytes, 1 = 8 bytes |
| rf_we | output | 1 | Base register writeback strobe |
| rf_waddr | output | 5 | Writeback register index |
| rf_wdata | output | 64 | Writeback value |
| sp_we | output | 1 | Stack pointer writeback strobe |
| sp_wdata | output | 64 | New stack pointer |
| done | output | 1 | End of request pulse |
| illegal | output | 1 | Unhandled encoding, valid with done |
| align_fault | output | 1 | Stack misalignment, valid with done |

## Verification
A wrong sequencer state shows up within one or two cycles, as a write count other than two, or as a writeback that lands before the second memory write. A wrong captured address shows up at the very first handshake, as a write to the wrong slot. A second slot that is not adjacent to the first shows up on the next handshake. If the base data is captured after writeback instead of at start, the overlap cases store the updated address instead of the old one, and this is visible on `mem_wdata` at the first write. A fault path that does not stop the request shows a `mem_valid` in the cycle right after start, where only `done` is expected.

// File: rtl/stp_pkg.sv
package stp_pkg;
    localparam int XLEN     = 64;
    localparam int IW       = 32;
    localparam int RIDX     = 5;
    localparam int IMMW     = 7;
    localparam int SP_IDX   = 31;
    localparam int SP_ALIGN = 16;
    localparam int HALF     = XLEN / 2;

    typedef enum logic [1:0] {
        FORM_NONE = 2'b00,
        FORM_POST = 2'b01,
        FORM_OFFS = 2'b10,
        FORM_PRE  = 2'b11
    } form_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR1,
        ST_WR2,
        ST_WB,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [1:0]      opc;
        logic [4:0]      spare;
        form_e           form;
        logic            is_load;
        logic [IMMW-1:0] imm;
        logic [RIDX-1:0] rt2;
        logic [RIDX-1:0] rn;
        logic [RIDX-1:0] rt;
    } ifields_t;

    typedef struct packed {
        logic            bad;
        logic            wide;
        logic            wback;
        logic            postidx;
        logic            use_sp;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rt2;
        logic [RIDX-1:0] rn;
        logic [XLEN-1:0] offset;
    } dec_t;

    typedef struct packed {
        logic            wide;
        logic            wback;
        logic            use_sp;
        logic [RIDX-1:0] rn;
        logic [XLEN-1:0] ea;
        logic [XLEN-1:0] ea2;
        logic [XLEN-1:0] wb_addr;
        logic [XLEN-1:0] d1;
        logic [XLEN-1:0] d2;
    } ctx_t;

    function automatic logic [XLEN-1:0] elem_data(input logic [XLEN-1:0] v, input logic wide);
        return wide ? v : {{(XLEN-HALF){1'b0}}, v[HALF-1:0]};
    endfunction
endpackage

// File: rtl/stp_decode.sv
module stp_decode
    import stp_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);
    ifields_t f;
    logic [XLEN-1:0] sext;
    logic            bad_opc;
    logic            bad_form;

    always_comb begin
        f        = ifields_t'(instr);
        sext     = {{(XLEN-IMMW){f.imm[IMMW-1]}}, f.imm};
        bad_opc  = (f.opc == 2'b11) || (!f.is_load && f.opc[0]) || f.is_load;
        bad_form = (f.form == FORM_NONE);

        dec.bad     = bad_opc || bad_form;
        dec.wide    = f.opc[1];
        dec.wback   = (f.form == FORM_POST) || (f.form == FORM_PRE);
        dec.postidx = (f.form == FORM_POST);
        dec.use_sp  = (f.rn == RIDX'(SP_IDX));
        dec.rt      = f.rt;
        dec.rt2     = f.rt2;
        dec.rn      = f.rn;
        dec.offset  = f.opc[1] ? (sext << 3) : (sext << 2);
    end

    logic unused_spare;
    assign unused_spare = ^f.spare;
endmodule

// File: rtl/stp_agen.sv
module stp_agen
    import stp_pkg::*;
(
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    input  logic            postidx,
    input  logic            wide,
    output logic [XLEN-1:0] ea,
    output logic [XLEN-1:0] ea2,
    output logic [XLEN-1:0] wb_addr
);
    logic [XLEN-1:0] step;

    always_comb begin
        wb_addr = base + offset;
        ea      = postidx ? base : wb_addr;
        step    = wide ? XLEN'(8) : XLEN'(4);
        ea2     = ea + step;
    end
endmodule

// File: rtl/stp_ctrl.sv
module stp_ctrl
    import stp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       stop_early,
    input  logic       wback,
    input  logic       mem_ready,
    output seq_state_e state,
    output logic       accept
);
    seq_state_e nxt;

    assign accept = (state == ST_IDLE) && start;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = stop_early ? ST_DONE : ST_WR1;
            ST_WR1:  if (mem_ready) nxt = ST_WR2;
            ST_WR2:  if (mem_ready) nxt = wback ? ST_WB : ST_DONE;
            ST_WB:   nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/stp_seq.sv
module stp_seq
    import stp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [IW-1:0]   instr,
    output logic            busy,
    output logic [RIDX-1:0] rf_raddr_a,
    input  logic [XLEN-1:0] rf_rdata_a,
    output logic [RIDX-1:0] rf_raddr_b,
    input  logic [XLEN-1:0] rf_rdata_b,
    output logic [RIDX-1:0] rf_raddr_n,
    input  logic [XLEN-1:0] rf_rdata_n,
    input  logic [XLEN-1:0] sp_in,
    output logic            mem_valid,
    input  logic            mem_ready,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_size,
    output logic            rf_we,
    output logic [RIDX-1:0] rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            sp_we,
    output logic [XLEN-1:0] sp_wdata,
    output logic            done,
    output logic            illegal,
    output logic            align_fault
);
    localparam int ALB = $clog2(SP_ALIGN);

    dec_t            dec;
    seq_state_e      state;
    logic            accept;
    logic            misalign;
    logic [XLEN-1:0] base_live;
    logic [XLEN-1:0] ea, ea2, wba;
    ctx_t            ctx;
    logic            flag_bad, flag_mis;

    stp_decode u_dec (.instr(instr), .dec(dec));

    assign rf_raddr_a = dec.rt;
    assign rf_raddr_b = dec.rt2;
    assign rf_raddr_n = dec.rn;
    assign base_live  = dec.use_sp ? sp_in : rf_rdata_n;
    assign misalign   = dec.use_sp && (sp_in[ALB-1:0] != '0);

    stp_agen u_agen (
        .base    (base_live),
        .offset  (dec.offset),
        .postidx (dec.postidx),
        .wide    (dec.wide),
        .ea      (ea),
        .ea2     (ea2),
        .wb_addr (wba)
    );

    stp_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .stop_early (dec.bad || misalign),
        .wback      (ctx.wback),
        .mem_ready  (mem_ready),
        .state      (state),
        .accept     (accept)
    );

    // Everything is captured at acceptance, so register values are pre-writeback.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx      <= '0;
            flag_bad <= 1'b0;
            flag_mis <= 1'b0;
        end else if (accept) begin
            ctx.wide    <= dec.wide;
            ctx.wback   <= dec.wback;
            ctx.use_sp  <= dec.use_sp;
            ctx.rn      <= dec.rn;
            ctx.ea      <= ea;
            ctx.ea2     <= ea2;
            ctx.wb_addr <= wba;
            ctx.d1      <= elem_data(rf_rdata_a, dec.wide);
            ctx.d2      <= elem_data(rf_rdata_b, dec.wide);
            flag_bad    <= dec.bad;
            flag_mis    <= !dec.bad && misalign;
        end
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        mem_valid   = (state == ST_WR1) || (state == ST_WR2);
        mem_addr    = (state == ST_WR2) ? ctx.ea2 : ctx.ea;
        mem_wdata   = (state == ST_WR2) ? ctx.d2 : ctx.d1;
        mem_size    = ctx.wide;
        rf_we       = (state == ST_WB) && !ctx.use_sp;
        sp_we       = (state == ST_WB) && ctx.use_sp;
        rf_waddr    = ctx.rn;
        rf_wdata    = ctx.wb_addr;
        sp_wdata    = ctx.wb_addr;
        done        = (state == ST_DONE);
        illegal     = done && flag_bad;
        align_fault = done && flag_mis;
    end
endmodule

// File: rtl/stp_seq_chk.sv
module stp_seq_chk
    import stp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            mem_valid,
    input logic            mem_ready,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_size,
    input logic            rf_we,
    input logic            sp_we,
    input logic            done,
    input logic            illegal,
    input logic            align_fault
);
    logic [1:0]      wr_cnt;
    logic            wb_seen;
    logic [XLEN-1:0] first_addr;
    logic            hs;

    assign hs = mem_valid && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt     <= '0;
            wb_seen    <= 1'b0;
            first_addr <= '0;
        end else if (start && !busy) begin
            wr_cnt  <= '0;
            wb_seen <= 1'b0;
        end else begin
            if (hs && wr_cnt != 2'd3) wr_cnt <= wr_cnt + 2'd1;
            if (hs && wr_cnt == 2'd0) first_addr <= mem_addr;
            if (rf_we || sp_we) wb_seen <= 1'b1;
        end
    end

    AST_SECOND_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        hs && wr_cnt == 2'd1 |-> mem_addr == first_addr + (mem_size ? XLEN'(8) : XLEN'(4))); // R5
    AST_TWO_WRITES: assert property (@(posedge clk) disable iff (rst)
        done && !illegal && !align_fault |-> wr_cnt == 2'd2); // R5
    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
        done && illegal |-> wr_cnt == 2'd0 && !wb_seen); // R2
    AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (rst)
        done && align_fault |-> wr_cnt == 2'd0 && !wb_seen); // R7
    AST_WB_AFTER_WRITES: assert property (@(posedge clk) disable iff (rst)
        rf_we || sp_we |-> wr_cnt == 2'd2); // R6
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata)); // R9
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_valid, rf_we, sp_we, done})); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
endmodule

bind stp_seq stp_seq_chk u_chk (.*);

// File: tb/stp_seq_tb.sv
module stp_seq_tb;
    import stp_pkg::*;

    logic            clk = 1'b0;
    logic            rst;
    logic            start;
    logic [IW-1:0]   instr;
    logic            busy;
    logic [RIDX-1:0] rf_raddr_a, rf_raddr_b, rf_raddr_n, rf_waddr;
    logic [XLEN-1:0] rf_rdata_a, rf_rdata_b, rf_rdata_n, sp_in;
    logic            mem_valid, mem_ready, mem_size;
    logic [XLEN-1:0] mem_addr, mem_wdata, rf_wdata, sp_wdata;
    logic            rf_we, sp_we, done, illegal, align_fault;

    logic [XLEN-1:0] rf [32];
    logic [XLEN-1:0] sp;

    int tests = 0, fails = 0, cycles = 0;
    int nw, lat;
    logic [XLEN-1:0] wa [4];
    logic [XLEN-1:0] wd [4];
    logic            wsz [4];
    int              nwb;
    logic [XLEN-1:0] wbv;
    logic            wb_to_sp, got_ill, got_mis;

    always #2 clk = ~clk;

    assign rf_rdata_a = rf[rf_raddr_a];
    assign rf_rdata_b = rf[rf_raddr_b];
    assign rf_rdata_n = rf[rf_raddr_n];
    assign sp_in      = sp;

    stp_seq u_dut (.*);

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (sp_we) sp <= sp_wdata;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [31:0] enc(input logic [1:0] opc, input logic [1:0] form,
                                        input logic ld, input logic [6:0] imm,
                                        input logic [4:0] rt2, input logic [4:0] rn,
                                        input logic [4:0] rt);
        return {opc, 5'b10100, form, ld, imm, rt2, rn, rt};
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] w, input int stall);
        @(negedge clk);
        instr = w;
        start = 1'b1;
        nw = 0; nwb = 0; lat = 0; got_ill = 0; got_mis = 0; wb_to_sp = 0;
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            start     = 1'b0;
            mem_ready = (c > stall);
            if (mem_valid && mem_ready && nw < 4) begin
                wa[nw] = mem_addr; wd[nw] = mem_wdata; wsz[nw] = mem_size; nw++;
            end
            if (rf_we) begin nwb++; wbv = rf_wdata; end
            if (sp_we) begin nwb++; wbv = sp_wdata; wb_to_sp = 1; end
            if (done) begin
                lat = c; got_ill = illegal; got_mis = align_fault;
                break;
            end
        end
        mem_ready = 1'b1;
    endtask

    task automatic t_reset;
        chk("R10 busy after reset", XLEN'(busy), 0);
        chk("R10 outputs idle after reset", XLEN'({mem_valid, rf_we, sp_we, done}), 0);
    endtask

    task automatic t_pre64;
        rf[3] = 64'h1000; rf[1] = 64'hAAAA_0000_1111_2222; rf[2] = 64'hBBBB_3333_4444_5555;
        run(enc(2'b10, 2'b11, 0, 7'h7E, 5'd2, 5'd3, 5'd1), 0);
        chk("R5 write count", XLEN'(nw), 2);
        chk("R4 pre addr", wa[0], 64'h0FF0);
        chk("R5 second addr", wa[1], 64'h0FF8);
        chk("R1 data1 wide", wd[0], 64'hAAAA_0000_1111_2222);
        chk("R5 data2", wd[1], 64'hBBBB_3333_4444_5555);
        chk("R1 size wide", XLEN'(wsz[0]), 1);
        chk("R6 pre writeback", rf[3], 64'h0FF0);
        chk("R10 latency wb", XLEN'(lat), 4);
    endtask

    task automatic t_post32_stall;
        rf[8] = 64'h2000; rf[4] = 64'hDEAD_BEEF_1234_5678; rf[9] = 64'hFFFF_FFFF_8765_4321;
        run(enc(2'b00, 2'b01, 0, 7'd63, 5'd9, 5'd8, 5'd4), 2);
        chk("R4 post addr", wa[0], 64'h2000);
        chk("R5 narrow second addr", wa[1], 64'h2004);
        chk("R1 narrow data1", wd[0], 64'h1234_5678);
        chk("R1 narrow data2", wd[1], 64'h8765_4321);
        chk("R1 size narrow", XLEN'(wsz[1]), 0);
        chk("R3 +252 post writeback", rf[8], 64'h20FC);
        chk("R9 stalled latency", XLEN'(lat), 6);
    endtask

    task automatic t_offs64;
        rf[10] = 64'h10000; rf[11] = 64'h1; rf[12] = 64'h2;
        run(enc(2'b10, 2'b10, 0, 7'h40, 5'd12, 5'd10, 5'd11), 0);
        chk("R3 -512 offset addr", wa[0], 64'hFE00);
        chk("R5 offset second", wa[1], 64'hFE08);
        chk("R6 no writeback count", XLEN'(nwb), 0);
        chk("R6 base unchanged", rf[10], 64'h10000);
        chk("R10 latency offset", XLEN'(lat), 3);
    endtask

    task automatic t_sp;
        sp = 64'h8000; rf[13] = 64'h13; rf[14] = 64'h14; rf[31] = 64'h5555;
        run(enc(2'b10, 2'b11, 0, 7'h7C, 5'd14, 5'd31, 5'd13), 0);
        chk("R7 sp base addr", wa[0], 64'h7FE0);
        chk("R7 writeback to sp", XLEN'(wb_to_sp), 1);
        chk("R7 sp updated", sp, 64'h7FE0);
        chk("R7 rf31 untouched", rf[31], 64'h5555);
    endtask

    task automatic t_misalign;
        sp = 64'h8008;
        run(enc(2'b10, 2'b11, 0, 7'h7E, 5'd2, 5'd31, 5'd1), 0);
        chk("R7 fault flag", XLEN'(got_mis), 1);
        chk("R7 no writes", XLEN'(nw + nwb), 0);
        chk("R7 sp unchanged", sp, 64'h8008);
        chk("R7 fault latency", XLEN'(lat), 1);
    endtask

    task automatic t_illegal;
        logic [31:0] bad [4];
        bad[0] = enc(2'b11, 2'b11, 0, 7'h1, 5'd2, 5'd3, 5'd1);
        bad[1] = enc(2'b01, 2'b11, 0, 7'h1, 5'd2, 5'd3, 5'd1);
        bad[2] = enc(2'b10, 2'b11, 1, 7'h1, 5'd2, 5'd3, 5'd1);
        bad[3] = enc(2'b10, 2'b00, 0, 7'h1, 5'd2, 5'd3, 5'd1);
        rf[3] = 64'h500;
        for (int i = 0; i < 4; i++) begin
            run(bad[i], 0);
            chk("R2 illegal flag", XLEN'(got_ill), 1);
            chk("R2 no writes", XLEN'(nw + nwb), 0);
            chk("R2 latency", XLEN'(lat), 1);
        end
        chk("R2 base untouched", rf[3], 64'h500);
    endtask

    task automatic t_overlap;
        rf[5] = 64'h3000; rf[6] = 64'h66;
        run(enc(2'b10, 2'b11, 0, 7'd1, 5'd6, 5'd5, 5'd5), 0);
        chk("R8 rt==rn stores old base", wd[0], 64'h3000);
        chk("R8 address", wa[0], 64'h3008);
        chk("R6 writeback", rf[5], 64'h3008);
        rf[7] = 64'h1_0000_4000; rf[15] = 64'h77;
        run(enc(2'b00, 2'b01, 0, 7'h40, 5'd7, 5'd7, 5'd15), 0);
        chk("R8 rt2==rn stores old base", wd[1], 64'h4000);
        chk("R3 -256 post writeback", rf[7], 64'h1_0000_3F00);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = '0;
        sp = '0; start = 0; instr = '0; mem_ready = 1'b1; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pre64();
        t_post32_stall();
        t_offs64();
        t_sp();
        t_misalign();
        t_illegal();
        t_overlap();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule